// File: doc/BRIEF.md
# Bit-Oriented Anticollision Frame Builder

This block is the reader-side sequencer for one cascade level of the ISO 14443A bit-oriented anticollision loop. A `start` pulse latches the select code and sends the opening command: the select code followed by a count byte of 0x20. After each command the block takes the card response as a byte stream. The end of that stream carries three status values: a collision flag, a 5-bit collision position counted from the first received bit, and a flag that marks that position as unusable. When a collision is reported, the block keeps the UID bits that arrived before the collision point. It sets the colliding bit to the value on `coll_choice` and discards everything after it. It then sends a new command that carries those known bits, together with the matching count byte and the partial-byte framing values that the transmitter and receiver need.

Bits are numbered LSB-first. Position 1 is bit 0 of UID byte 0, and the known-bit count grows from one round to the next. The loop ends when a response arrives with no collision and its check byte matches the XOR of the four UID bytes. It also ends on a failure: an unusable position, a check-byte mismatch, or too many command frames.

Both data paths use valid/ready. The transmit side holds its byte until the consumer accepts it. The receive side is ready only while a response is awaited. A byte offered at any other time stays pending, so the producer can apply back-pressure freely and nothing is lost.

Top module: `anticoll_frame_builder`

## Requirements
- R1: After `start` the first frame is exactly two bytes: `sel_code`, then 0x20. `tx_last` is set on the second byte. `tx_last_bits`, `rx_align`, `bit_framing` and `tx_uid_bytes` are all zero.
- R2: With K known UID bits and T = 16 + K, the count byte (the second byte of every frame) is floor(T/8) in bits 7:4 and T mod 8 in bits 3:0. Five known bits give 0x25.
- R3: A reported collision position of 0 counts as 32.
- R4: `tx_last_bits` and `rx_align` both equal T mod 8, and `bit_framing` holds `rx_align` in bits 6:4 and `tx_last_bits` in bits 2:0.
- R5: `tx_uid_bytes` equals ceil(K/8), and exactly that many UID bytes follow the count byte before `tx_last`.
- R6: On a collision at relative position p (bit index K+p-1), the next frame carries the earlier bits unchanged, the collision bit equal to `coll_choice`, and zeros above it. The known count becomes K+p.
- R7: Response byte n is placed at UID byte floor(K/8)+n, where byte index 4 is the check byte. Bits already known are kept, whatever the response carries in those positions.
- R8: A collision whose position-unusable flag is set, or whose absolute position exceeds 32, ends the loop with `done`, `err` and `err_code` = 2.
- R9: A response without a collision ends the loop. If the check byte equals the XOR of the four UID bytes, `uid_ok` and `bcc_ok` are set and `uid` holds byte 0 in bits 7:0. Otherwise `err` is set with `err_code` = 1, `bcc_ok` = 0 and `uid` = 0.
- R10: A collision that would require more than MAX_ITER (32) command frames ends the loop with `err_code` = 3.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold steady. `rx_ready` is high only while a response is awaited, and never together with `tx_valid`.
- R12: `start` is ignored while `busy`. The frame in progress and the latched select code do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a loop (ignored while busy) |
| sel_code | input | 8 | Select code latched at start |
| coll_choice | input | 1 | Value given to a colliding bit |
| tx_valid | output | 1 | Command byte available |
| tx_ready | input | 1 | Consumer accepts command byte |
| tx_data | output | 8 | Command byte |
| tx_last | output | 1 | Final byte of the command |
| tx_last_bits | output | 3 | Valid bits in the final transmitted byte (0 = all 8) |
| rx_align | output | 3 | Bit position of the first received bit |
| bit_framing | output | 8 | Packed rx_align and tx_last_bits |
| tx_uid_bytes | output | 3 | UID bytes carried after the count byte |
| rx_valid | input | 1 | Response byte available |
| rx_ready | output | 1 | Response byte accepted |
| rx_data | input | 8 | Response byte |
| rx_last | input | 1 | Final response byte; status below is valid with it |
| rx_coll | input | 1 | Collision seen in this response |
| rx_coll_pos | input | 5 | Collision position relative to the first received bit |
| rx_pos_bad | input | 1 | Collision position is unusable |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle pulse at loop end |
| uid_ok | output | 1 | UID resolved and check byte correct |
| uid | output | 32 | Resolved UID, zero unless uid_ok |
| err | output | 1 | Loop ended in failure |
| err_code | output | 2 | 1 check byte, 2 position, 3 frame limit |
| bcc_ok | output | 1 | Check byte matched at the final response |

## Verification
A wrong bit in the UID store, or a wrong known-bit count, appears in the very next command frame. It shows up either as a changed count byte and framing fields or as a wrong masked UID byte, one frame after the response that caused it. Because of this, the checks compare every byte and sideband field of each frame and do not wait for the final UID. A fault in the outcome decision appears on `err_code`, `uid_ok` and `uid` two clocks after the last response byte. A lost back-pressure stall shows as `tx_data` changing while `tx_ready` is held low.

// File: rtl/anticoll_pkg.sv
package anticoll_pkg;
  localparam int UID_BYTES  = 4;
  localparam int RESP_BYTES = UID_BYTES + 1;
  localparam int UID_BITS   = UID_BYTES * 8;
  localparam int STORE_BITS = RESP_BYTES * 8;
  localparam int KNOWN_W    = $clog2(UID_BITS + 1);
  localparam int IDX_W      = $clog2(RESP_BYTES + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TX,
    ST_RX,
    ST_EVAL
  } ctl_state_t;

  typedef enum logic [1:0] {
    FAIL_NONE  = 2'd0,
    FAIL_BCC   = 2'd1,
    FAIL_POS   = 2'd2,
    FAIL_LIMIT = 2'd3
  } fail_t;
endpackage

// File: rtl/anticoll_frame_calc.sv
module anticoll_frame_calc
  import anticoll_pkg::*;
(
  input  logic [KNOWN_W-1:0] known_bits,
  output logic [7:0]         nvb,
  output logic [2:0]         last_bits,
  output logic [2:0]         uid_bytes
);
  localparam int TOT_W = KNOWN_W + 1;

  logic [TOT_W-1:0] total;
  logic [3:0]       whole;

  always_comb begin
    total     = TOT_W'(16) + TOT_W'(known_bits);
    whole     = total[TOT_W-1:3];
    nvb       = {whole, 1'b0, total[2:0]};
    last_bits = total[2:0];
    uid_bytes = 3'(whole - 4'd2) + {2'b00, |total[2:0]};
  end

  always_comb begin
    if (known_bits <= KNOWN_W'(UID_BITS))
      AST_UID_BYTES_RANGE: assert (uid_bytes <= 3'(UID_BYTES)); // R5
  end
endmodule

// File: rtl/anticoll_uid_store.sv
module anticoll_uid_store
  import anticoll_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [KNOWN_W-1:0]    keep_cnt,
  input  logic                  cut_en,
  input  logic [KNOWN_W-1:0]    cut_pos,
  input  logic                  cut_val,
  input  logic [1:0]            rd_idx,
  output logic [7:0]            rd_byte,
  output logic [UID_BITS-1:0]   uid_bits,
  output logic [7:0]            bcc_byte
);
  logic [STORE_BITS-1:0] bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    for (int i = 0; i < STORE_BITS; i++) begin
      if (clear) begin
        bits_d[i] = 1'b0;
      end else if (cut_en) begin
        if (i + 1 == int'(cut_pos))     bits_d[i] = cut_val;
        else if (i + 1 > int'(cut_pos)) bits_d[i] = 1'b0;
      end else if (wr_en && int'(wr_idx) == i / 8 && i >= int'(keep_cnt)) begin
        bits_d[i] = wr_data[i % 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign rd_byte  = bits_q[8*rd_idx +: 8];
  assign uid_bits = bits_q[UID_BITS-1:0];
  assign bcc_byte = bits_q[STORE_BITS-1:UID_BITS];

  AST_KEEP_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear && !cut_en && wr_idx == '0 && keep_cnt >= KNOWN_W'(8))
      |=> bits_q[7:0] == $past(bits_q[7:0])); // R7
endmodule

// File: rtl/anticoll_bcc_check.sv
module anticoll_bcc_check
  import anticoll_pkg::*;
(
  input  logic [UID_BITS-1:0] uid_bits,
  input  logic [7:0]          bcc_byte,
  output logic                match
);
  logic [7:0] fold [UID_BYTES+1];

  assign fold[0] = 8'h00;
  for (genvar g = 0; g < UID_BYTES; g++) begin : g_fold
    assign fold[g+1] = fold[g] ^ uid_bits[8*g +: 8];
  end

  assign match = (fold[UID_BYTES] == bcc_byte);
endmodule

// File: rtl/anticoll_frame_builder.sv
module anticoll_frame_builder
  import anticoll_pkg::*;
#(
  parameter int MAX_ITER = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  sel_code,
  input  logic        coll_choice,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic [2:0]  tx_last_bits,
  output logic [2:0]  rx_align,
  output logic [7:0]  bit_framing,
  output logic [2:0]  tx_uid_bytes,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_coll,
  input  logic [4:0]  rx_coll_pos,
  input  logic        rx_pos_bad,
  output logic        busy,
  output logic        done,
  output logic        uid_ok,
  output logic [31:0] uid,
  output logic        err,
  output logic [1:0]  err_code,
  output logic        bcc_ok
);
  localparam int ITER_W = $clog2(MAX_ITER + 1);
  localparam int ABS_W  = KNOWN_W + 1;

  ctl_state_t          state_q;
  logic [7:0]          sel_q;
  logic [KNOWN_W-1:0]  known_q;
  logic [IDX_W-1:0]    tx_idx_q, rx_idx_q;
  logic [ITER_W-1:0]   frames_q;
  logic                ev_coll_q, ev_bad_q;
  logic [4:0]          ev_pos_q;
  logic                done_q, uid_ok_q, err_q, bcc_ok_q;
  fail_t               err_code_q;

  logic [7:0]          nvb;
  logic [2:0]          last_bits, uid_bytes;
  logic [7:0]          rd_byte, bcc_byte;
  logic [UID_BITS-1:0] uid_bits;
  logic                bcc_match;
  logic                store_clear, store_wr, cut_en;
  logic [ABS_W-1:0]    rel_pos, abs_pos;
  logic                resolve, fail;
  fail_t               fail_code;

  anticoll_frame_calc i_calc (
    .known_bits (known_q),
    .nvb        (nvb),
    .last_bits  (last_bits),
    .uid_bytes  (uid_bytes)
  );

  assign store_clear = (state_q == ST_IDLE) && start;
  assign store_wr    = (state_q == ST_RX) && rx_valid && (rx_idx_q < IDX_W'(RESP_BYTES));

  anticoll_uid_store i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (store_clear),
    .wr_en    (store_wr),
    .wr_idx   (rx_idx_q),
    .wr_data  (rx_data),
    .keep_cnt (known_q),
    .cut_en   (cut_en),
    .cut_pos  (abs_pos[KNOWN_W-1:0]),
    .cut_val  (coll_choice),
    .rd_idx   (2'(tx_idx_q - IDX_W'(2))),
    .rd_byte  (rd_byte),
    .uid_bits (uid_bits),
    .bcc_byte (bcc_byte)
  );

  anticoll_bcc_check i_bcc (
    .uid_bits (uid_bits),
    .bcc_byte (bcc_byte),
    .match    (bcc_match)
  );

  // Outcome of one response, evaluated the cycle after its last byte.
  always_comb begin
    rel_pos   = (ev_pos_q == 5'd0) ? ABS_W'(32) : ABS_W'(ev_pos_q);
    abs_pos   = ABS_W'(known_q) + rel_pos;
    resolve   = 1'b0;
    fail      = 1'b0;
    fail_code = FAIL_NONE;
    if (ev_coll_q) begin
      if (ev_bad_q || abs_pos > ABS_W'(UID_BITS)) begin
        fail      = 1'b1;
        fail_code = FAIL_POS;
      end else if (frames_q >= ITER_W'(MAX_ITER)) begin
        fail      = 1'b1;
        fail_code = FAIL_LIMIT;
      end else begin
        resolve   = 1'b1;
      end
    end else if (!bcc_match) begin
      fail      = 1'b1;
      fail_code = FAIL_BCC;
    end
    cut_en = (state_q == ST_EVAL) && resolve;
  end

  always_comb begin
    case (tx_idx_q)
      IDX_W'(0): tx_data = sel_q;
      IDX_W'(1): tx_data = nvb;
      default:   tx_data = rd_byte;
    endcase
  end

  assign tx_valid     = (state_q == ST_TX);
  assign tx_last      = (tx_idx_q == IDX_W'(uid_bytes) + IDX_W'(1));
  assign rx_ready     = (state_q == ST_RX);
  assign busy         = (state_q != ST_IDLE);
  assign tx_last_bits = last_bits;
  assign rx_align     = last_bits;
  assign bit_framing  = {1'b0, last_bits, 1'b0, last_bits};
  assign tx_uid_bytes = uid_bytes;
  assign done         = done_q;
  assign uid_ok       = uid_ok_q;
  assign uid          = uid_ok_q ? uid_bits : '0;
  assign err          = err_q;
  assign err_code     = err_code_q;
  assign bcc_ok       = bcc_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sel_q      <= '0;
      known_q    <= '0;
      tx_idx_q   <= '0;
      rx_idx_q   <= '0;
      frames_q   <= '0;
      ev_coll_q  <= 1'b0;
      ev_bad_q   <= 1'b0;
      ev_pos_q   <= '0;
      done_q     <= 1'b0;
      uid_ok_q   <= 1'b0;
      err_q      <= 1'b0;
      err_code_q <= FAIL_NONE;
      bcc_ok_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            sel_q      <= sel_code;
            known_q    <= '0;
            tx_idx_q   <= '0;
            frames_q   <= ITER_W'(1);
            uid_ok_q   <= 1'b0;
            err_q      <= 1'b0;
            err_code_q <= FAIL_NONE;
            bcc_ok_q   <= 1'b0;
            state_q    <= ST_TX;
          end
        end
        ST_TX: begin
          if (tx_ready) begin
            if (tx_last) begin
              rx_idx_q <= IDX_W'(known_q[KNOWN_W-1:3]);
              state_q  <= ST_RX;
            end else begin
              tx_idx_q <= tx_idx_q + IDX_W'(1);
            end
          end
        end
        ST_RX: begin
          if (rx_valid) begin
            if (rx_idx_q < IDX_W'(RESP_BYTES)) rx_idx_q <= rx_idx_q + IDX_W'(1);
            if (rx_last) begin
              ev_coll_q <= rx_coll;
              ev_pos_q  <= rx_coll_pos;
              ev_bad_q  <= rx_pos_bad;
              state_q   <= ST_EVAL;
            end
          end
        end
        ST_EVAL: begin
          if (resolve) begin
            known_q  <= abs_pos[KNOWN_W-1:0];
            tx_idx_q <= '0;
            frames_q <= frames_q + ITER_W'(1);
            state_q  <= ST_TX;
          end else begin
            done_q     <= 1'b1;
            err_q      <= fail;
            err_code_q <= fail_code;
            uid_ok_q   <= !fail;
            bcc_ok_q   <= !fail;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R11
  AST_TX_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready)); // R11
  AST_NVB_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_idx_q == IDX_W'(1)) |->
      (tx_data[7:4] >= 4'd2 && tx_data[7:4] <= 4'd6 && !tx_data[3])); // R2
  AST_KNOWN_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX && $past(state_q) == ST_EVAL) |-> (known_q > $past(known_q))); // R6
  AST_DONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (uid_ok ^ err)); // R9
  AST_UIDOK_BCC: assert property (@(posedge clk) disable iff (!rst_n)
    uid_ok |-> bcc_ok); // R9
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    frames_q <= ITER_W'(MAX_ITER)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(sel_q)); // R12
endmodule

// File: tb/test_anticoll_frame_builder.sv
module test_anticoll_frame_builder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  sel_code = 8'h93;
  logic        coll_choice = 1'b1;
  logic        tx_valid, tx_last, rx_ready, busy, done, uid_ok, err, bcc_ok;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data, bit_framing;
  logic [2:0]  tx_last_bits, rx_align, tx_uid_bytes;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_coll = 1'b0, rx_pos_bad = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic [4:0]  rx_coll_pos = 5'd0;
  logic [31:0] uid;
  logic [1:0]  err_code;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] fr;
  int          fr_n;
  logic [2:0]  s_last, s_align, s_ub;
  logic [7:0]  s_frm;

  always #4 clk = ~clk;

  anticoll_frame_builder i_anticoll_frame_builder (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_code(sel_code), .coll_choice(coll_choice),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_last_bits(tx_last_bits), .rx_align(rx_align), .bit_framing(bit_framing),
    .tx_uid_bytes(tx_uid_bytes), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .rx_coll(rx_coll), .rx_coll_pos(rx_coll_pos), .rx_pos_bad(rx_pos_bad),
    .busy(busy), .done(done), .uid_ok(uid_ok), .uid(uid), .err(err), .err_code(err_code),
    .bcc_ok(bcc_ok)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [7:0] sc, input logic ch);
    @(negedge clk);
    sel_code = sc; coll_choice = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Collect one command frame; optional stall before the first byte is accepted.
  task automatic get_frame(input int stall);
    logic [7:0] d0;
    bit lst;
    int g;
    fr = '0; fr_n = 0; tx_ready = 1'b0; g = 0;
    while (!tx_valid && g < 100) begin @(negedge clk); g++; end
    s_last = tx_last_bits; s_align = rx_align; s_frm = bit_framing; s_ub = tx_uid_bytes;
    if (stall > 0) begin
      d0 = tx_data;
      repeat (stall) @(negedge clk);
      chk("R11 tx_data held under stall", {56'd0, tx_data}, {56'd0, d0});
      chk("R11 tx_valid held under stall", {63'd0, tx_valid}, 64'd1);
    end
    do begin
      fr[8*fr_n +: 8] = tx_data;
      fr_n++;
      lst = tx_last;
      tx_ready = 1'b1;
      @(negedge clk);
    end while (!lst && fr_n < 8);
    tx_ready = 1'b0;
  endtask

  task automatic chk_frame(input string req, input int n, input logic [63:0] bytes,
                           input logic [2:0] lb, input logic [2:0] ub);
    chk({req, " frame length"}, 64'(fr_n), 64'(n));
    chk({req, " frame bytes"}, fr, bytes);
    chk({req, " tx_last_bits"}, {61'd0, s_last}, {61'd0, lb});
    chk({req, " rx_align"}, {61'd0, s_align}, {61'd0, lb});
    chk({req, " bit_framing"}, {56'd0, s_frm}, {56'd0, 1'b0, lb, 1'b0, lb});
    chk({req, " tx_uid_bytes"}, {61'd0, s_ub}, {61'd0, ub});
  endtask

  task automatic send_resp(input logic [39:0] data, input int n, input logic coll,
                           input logic [4:0] pos, input logic bad);
    for (int k = 0; k < n; k++) begin
      int g;
      rx_valid = 1'b1; rx_data = data[8*k +: 8]; rx_last = (k == n - 1);
      rx_coll = coll; rx_coll_pos = pos; rx_pos_bad = bad;
      g = 0;
      while (!rx_ready && g < 100) begin @(negedge clk); g++; end
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_coll = 1'b0; rx_pos_bad = 1'b0;
  endtask

  task automatic finish_chk(input string req, input logic exp_ok, input logic [1:0] exp_code,
                            input logic [31:0] exp_uid);
    int g;
    g = 0;
    while (!done && g < 20) begin @(negedge clk); g++; end
    chk({req, " done pulse"}, {63'd0, done}, 64'd1);
    chk({req, " uid_ok"}, {63'd0, uid_ok}, {63'd0, exp_ok});
    chk({req, " err"}, {63'd0, err}, {63'd0, !exp_ok});
    chk({req, " err_code"}, {62'd0, err_code}, {62'd0, exp_code});
    chk({req, " bcc_ok"}, {63'd0, bcc_ok}, {63'd0, exp_ok});
    chk({req, " uid"}, {32'd0, uid}, {32'd0, exp_uid});
    @(negedge clk);
    chk({req, " done is one cycle"}, {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset;
    chk("reset busy", {63'd0, busy}, 64'd0);
    chk("reset tx_valid", {63'd0, tx_valid}, 64'd0);
    chk("reset rx_ready", {63'd0, rx_ready}, 64'd0);
    chk("reset done/err/uid_ok", {61'd0, done, err, uid_ok}, 64'd0);
  endtask

  // Two cards 86A083EE / 169A0A3B, collision at position 5, pick 1.
  task automatic t_two_cards_pick1;
    kick(8'h93, 1'b1);
    get_frame(2);
    chk_frame("R1 opening", 2, 64'h2093, 3'd0, 3'd0);
    // R12: a start pulse with another select code while waiting must be ignored
    @(negedge clk);
    chk("R12 rx_ready before ignored start", {63'd0, rx_ready}, 64'd1);
    sel_code = 8'h95; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 still waiting for response", {63'd0, rx_ready}, 64'd1);
    send_resp(40'h55555555E6, 5, 1'b1, 5'd5, 1'b0);
    get_frame(0);
    chk_frame("R2 R4 R5 R6 R12 pos5 pick1", 3, 64'h162593, 3'd5, 3'd1);
    send_resp(40'hBD3B0A9A0B, 5, 1'b0, 5'd0, 1'b0);
    finish_chk("R7 R9 card2", 1'b1, 2'd0, 32'h3B0A9A16);
  endtask

  task automatic t_two_cards_pick0;
    kick(8'h93, 1'b0);
    get_frame(0);
    chk_frame("R1 opening pick0", 2, 64'h2093, 3'd0, 3'd0);
    send_resp(40'h55555555E6, 5, 1'b1, 5'd5, 1'b0);
    get_frame(0);
    chk_frame("R6 pos5 pick0", 3, 64'h062593, 3'd5, 3'd1);
    send_resp(40'h4BEE83A086, 5, 1'b0, 5'd0, 1'b0);
    finish_chk("R9 card1", 1'b1, 2'd0, 32'hEE83A086);
  endtask

  task automatic t_pos_zero;
    kick(8'h93, 1'b1);
    get_frame(0);
    send_resp(40'h0021B2C3D4, 5, 1'b1, 5'd0, 1'b0);
    get_frame(0);
    chk_frame("R3 pos0 as 32", 6, 64'hA1B2C3D46093, 3'd0, 3'd4);
    send_resp(40'h04, 1, 1'b0, 5'd0, 1'b0);
    finish_chk("R7 R9 bcc-only response", 1'b1, 2'd0, 32'hA1B2C3D4);
  endtask

  task automatic t_multi_step;
    kick(8'h93, 1'b0);
    get_frame(0);
    send_resp(40'h000000F75A, 5, 1'b1, 5'd12, 1'b0);
    get_frame(0);
    chk_frame("R2 R6 pos12", 4, 64'h075A3493, 3'd4, 3'd2);
    coll_choice = 1'b1;
    send_resp(40'h0000003BEF, 4, 1'b1, 5'd7, 1'b0);
    get_frame(0);
    chk_frame("R6 R7 second collision", 5, 64'h07E75A4393, 3'd3, 3'd3);
    send_resp(40'h6210CA, 3, 1'b0, 5'd0, 1'b0);
    finish_chk("R7 R9 three rounds", 1'b1, 2'd0, 32'h10CFE75A);
  endtask

  task automatic t_bcc_bad;
    kick(8'h93, 1'b1);
    get_frame(0);
    send_resp(40'h0044332211, 5, 1'b0, 5'd0, 1'b0);
    finish_chk("R9 check byte mismatch", 1'b0, 2'd1, 32'h0);
  endtask

  task automatic t_pos_invalid;
    kick(8'h93, 1'b1);
    get_frame(0);
    send_resp(40'h0000000000, 5, 1'b1, 5'd3, 1'b1);
    finish_chk("R8 position flagged bad", 1'b0, 2'd2, 32'h0);
    kick(8'h93, 1'b1);
    get_frame(0);
    send_resp(40'h000000F75A, 5, 1'b1, 5'd12, 1'b0);
    get_frame(0);
    send_resp(40'h00000000, 4, 1'b1, 5'd25, 1'b0);
    finish_chk("R8 position beyond 32", 1'b0, 2'd2, 32'h0);
  endtask

  task automatic t_iter_limit;
    kick(8'h93, 1'b1);
    for (int k = 1; k <= 32; k++) begin
      get_frame(0);
      if (k == 32) chk_frame("R10 frame 32", 6, 64'h7FFFFFFF5793, 3'd7, 3'd4);
      send_resp(40'h00, 1, 1'b1, 5'd1, 1'b0);
    end
    finish_chk("R10 frame limit", 1'b0, 2'd3, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_two_cards_pick1();
    t_two_cards_pick0();
    t_pos_zero();
    t_multi_step();
    t_bcc_bad();
    t_pos_invalid();
    t_iter_limit();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule